// File: doc/BRIEF.md
# Nested Triangular Loop Generator

This block walks a two-level iteration space and issues one (outer, inner) index pair per valid cycle. The outer index climbs by one over a fixed range set by parameters. The inner index runs from zero up to a bound. That bound is either a constant, which gives a rectangular space, or the current outer index, which gives a triangular space. A parameter picks one of the two.

A pulse on `start` launches a run. While the run is active, every clock edge with `enable` high produces one output slot: either a valid index pair or an empty slot. When an outer value's inner iterations are used up, the inner loop has to be reinitialised, and this normally costs one empty slot. The `strategy` input is sampled at launch and decides how that slot is handled. It can leave the slot in place. It can drop the final inner iteration of every outer value (early exit). Or it can pre-advance the outer index so that the reload overlaps the first inner iteration (shifted range), which keeps `valid` high without a break. `finished` pulses once after the last valid slot.

Top module: `nested_loop_gen`

## Requirements
- R1: During and after reset, `valid` and `finished` are low and the block is idle.
- R2: A high `start` on an edge where `enable` is high and the block is idle launches a run. The first slot becomes visible after the next enabled edge. A `start` that arrives while a run is active is ignored.
- R3: The outer index takes the values OUTER_FIRST through OUTER_FIRST+OUTER_COUNT-1 in rising order. For each outer value o the inner index takes the values 0 to n(o)-1 in rising order. The base count n(o) is INNER_N when TRIANGULAR=0 and o when TRIANGULAR=1. Every valid slot carries its own correct pair.
- R4: `strategy` encoding: 0 = no hiding, 1 = early exit, 2 = shifted range. Code 3 is unsupported and behaves exactly like 0. The value is latched at launch.
- R5: With no hiding, the n(o) valid slots of each outer value are followed by exactly one empty slot.
- R6: With early exit, each outer value gets max(n(o)-1, 0) valid slots, each followed by one empty slot, so every end indication comes one slot sooner.
- R7: With shifted range, there is no empty slot between two outer values that both have a nonzero count, so `valid` stays continuously high across the nest.
- R8: An outer value with a zero count produces no valid slot. It costs exactly one empty slot.
- R9: `finished` is high for exactly one slot. That slot directly follows the last valid slot (or the last empty slot if nothing was valid), and `valid` is low in it.
- R10: An edge with `enable` low produces an empty slot (`valid` and `finished` low) and leaves the iteration state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| enable | input | 1 | Advance qualifier; low freezes the iteration |
| strategy | input | 2 | Dead-cycle handling, latched at launch |
| outer_idx | output | W | Outer index of the current slot |
| inner_idx | output | W | Inner index of the current slot |
| valid | output | 1 | Slot carries an index pair |
| finished | output | 1 | One-slot end-of-run pulse |

## Verification
The assertions assume that `strategy` is only meaningful at launch, and that in triangular mode the bound grows with the outer index, so a zero count can only appear at the start of the range. The stimulus follows both assumptions. It changes the strategy only between runs and uses rising outer ranges that start at zero or above. It applies the rectangular and triangular variants with every strategy code. It also inserts `enable` gaps and a stray `start` in the middle of a run.

// File: rtl/nested_loop_gen.sv
module nested_loop_gen #(
  parameter int W           = 8,
  parameter int OUTER_FIRST = 0,
  parameter int OUTER_COUNT = 8,
  parameter int INNER_N     = 8,
  parameter bit TRIANGULAR  = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         enable,
  input  logic [1:0]   strategy,
  output logic [W-1:0] outer_idx,
  output logic [W-1:0] inner_idx,
  output logic         valid,
  output logic         finished
);
  localparam logic [W-1:0] O_FIRST = W'(OUTER_FIRST);
  localparam logic [W-1:0] O_LAST  = W'(OUTER_FIRST + OUTER_COUNT - 1);
  localparam logic [W-1:0] I_CONST = W'(INNER_N);
  localparam logic [1:0]   S_NONE  = 2'd0;
  localparam logic [1:0]   S_EARLY = 2'd1;
  localparam logic [1:0]   S_SHIFT = 2'd2;

  function automatic logic [W-1:0] trip(input logic [W-1:0] o, input logic shorten);
    logic [W-1:0] base;
    base = TRIANGULAR ? o : I_CONST;
    if (shorten) trip = (base != '0) ? base - W'(1) : '0;
    else         trip = base;
  endfunction

  logic         busy, tail;
  logic [1:0]   sq;
  logic [W-1:0] oq, iq;

  wire          shifted = (sq == S_SHIFT);
  wire          early   = (sq == S_EARLY);
  wire [W-1:0]  o_cur   = shifted ? oq - W'(1) : oq;
  wire [W-1:0]  n_cur   = trip(o_cur, early);
  wire          has     = iq < n_cur;
  wire          at_end  = (iq + W'(1)) == n_cur;
  wire          o_end   = (o_cur == O_LAST);
  wire          step_o  = !has || (shifted && at_end);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; tail <= 1'b0; sq <= S_NONE;
      oq <= '0; iq <= '0;
      outer_idx <= '0; inner_idx <= '0;
      valid <= 1'b0; finished <= 1'b0;
    end else begin
      valid    <= 1'b0;
      finished <= 1'b0;
      if (enable) begin
        if (tail) begin
          tail     <= 1'b0;
          finished <= 1'b1;
        end else if (busy) begin
          valid     <= has;
          outer_idx <= o_cur;
          inner_idx <= iq;
          if (!step_o) iq <= iq + W'(1);
          else if (o_end) begin
            busy <= 1'b0;
            if (has) tail <= 1'b1;
            else     finished <= 1'b1;
          end else begin
            oq <= oq + W'(1);
            iq <= '0;
          end
        end else if (start) begin
          busy <= 1'b1;
          sq   <= (strategy == 2'd3) ? S_NONE : strategy;
          oq   <= (strategy == S_SHIFT) ? O_FIRST + W'(1) : O_FIRST;
          iq   <= '0;
        end
      end
    end
  end

  a_r9_done_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
    finished |-> !valid);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> !finished);
  a_r10_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(enable) |-> (!valid && !finished));
  a_r3_inner_bound: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (inner_idx < trip(outer_idx, early)));
  a_r3_inner_order: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(valid) && outer_idx == $past(outer_idx)) |-> inner_idx == $past(inner_idx) + W'(1));
  a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (shifted && $past(enable) && $past(valid) && !valid) |-> finished);
endmodule

// File: tb/sim_nested_loop_gen.sv
module sim_nested_loop_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go0 = 1'b0, go1 = 1'b0, en = 1'b1;
  logic [1:0] strat = 2'd0;
  logic [W-1:0] o0, i0, o1, i1;
  logic v0, d0, v1, d1;
  int checks = 0, errors = 0;
  int sel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nested_loop_gen #(.W(W), .OUTER_FIRST(0), .OUTER_COUNT(5), .INNER_N(0), .TRIANGULAR(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .start(go0), .enable(en), .strategy(strat),
    .outer_idx(o0), .inner_idx(i0), .valid(v0), .finished(d0));

  nested_loop_gen #(.W(W), .OUTER_FIRST(3), .OUTER_COUNT(3), .INNER_N(4), .TRIANGULAR(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .start(go1), .enable(en), .strategy(strat),
    .outer_idx(o1), .inner_idx(i1), .valid(v1), .finished(d1));

  wire       vs = sel ? v1 : v0;
  wire       ds = sel ? d1 : d0;
  wire [W-1:0] os = sel ? o1 : o0;
  wire [W-1:0] is_ = sel ? i1 : i0;

  int    ev[128], eo[128], ei[128], ed[128];
  string etag[128];
  int    elen;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push(input int v, input int o, input int i, input int d, input string t);
    ev[elen] = v; eo[elen] = o; ei[elen] = i; ed[elen] = d; etag[elen] = t;
    elen++;
  endtask

  task automatic build(input int s, input logic [1:0] md);
    int first, cnt, m, b, n, lastn;
    string gt;
    first = s ? 3 : 0;
    cnt   = s ? 3 : 5;
    m     = (md == 2'd3) ? 0 : int'(md);
    gt    = (md == 2'd3) ? "R4" : (m == 1) ? "R6" : (m == 2) ? "R7" : "R5";
    elen  = 0;
    lastn = 0;
    for (int k = 0; k < cnt; k++) begin
      int o;
      o = first + k;
      b = s ? 4 : o;
      n = (m == 1) ? ((b > 0) ? b - 1 : 0) : b;
      for (int i = 0; i < n; i++) push(1, o, i, 0, (k == 0 && i == 0) ? "R2" : "R3");
      if (m != 2) push(0, o, 0, (k == cnt - 1) ? 1 : 0, (n == 0) ? "R8" : gt);
      else if (n == 0) push(0, o, 0, (k == cnt - 1) ? 1 : 0, "R8");
      lastn = n;
    end
    if (m == 2 && lastn != 0) push(0, 0, 0, 1, "R9");
  endtask

  task automatic run(input int s, input logic [1:0] md, input int gap, input bit stray);
    int idx, cyc;
    bit used;
    build(s, md);
    sel = s;
    @(negedge clk);
    strat = md; en = 1'b1;
    if (s) go1 = 1'b1; else go0 = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go0 = 1'b0; go1 = 1'b0;
    idx = 0; cyc = 0;
    while (idx < elen && cyc < 1000) begin
      en = (gap != 0 && (cyc % gap) == gap - 1) ? 1'b0 : 1'b1;
      if (stray && cyc == 3) begin
        if (s) go1 = 1'b1; else go0 = 1'b1;
      end else begin
        go0 = 1'b0; go1 = 1'b0;
      end
      used = en;
      @(posedge clk);
      @(negedge clk);
      if (!used) begin
        check(!vs && !ds, "R10 gap slot", int'(vs) + int'(ds), 0);
      end else begin
        check(int'(vs) == ev[idx], ev[idx] ? etag[idx] : etag[idx], int'(vs), ev[idx]);
        if (ev[idx] != 0) begin
          check(int'(os) == eo[idx], "R3 outer", int'(os), eo[idx]);
          check(int'(is_) == ei[idx], "R3 inner", int'(is_), ei[idx]);
        end
        check(int'(ds) == ed[idx], "R9 finished", int'(ds), ed[idx]);
        idx++;
      end
      cyc++;
    end
    go0 = 1'b0; go1 = 1'b0; en = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check(!vs && !ds, "R9 quiet after finish", int'(vs) + int'(ds), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!v0 && !d0 && !v1 && !d1, "R1 reset outputs", int'(v0) + int'(d0) + int'(v1) + int'(d1), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!v0 && !d0 && !v1 && !d1, "R1 idle after reset", int'(v0) + int'(d0) + int'(v1) + int'(d1), 0);
    for (int s = 0; s < 2; s++)
      for (int md = 0; md < 4; md++)
        run(s, 2'(md), 0, 1'b0);
    run(0, 2'd2, 3, 1'b1);
    run(1, 2'd0, 4, 1'b1);
    run(0, 2'd1, 2, 1'b0);
    run(1, 2'd2, 0, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule